// File: doc/BRIEF.md
# Two-Phase Update Content-Addressable Memory

This block is a small content-addressable memory that holds 16 entries of 8-bit keys. A lookup is a single read of a bit-per-location lookup table, addressed by the presented key. The word it returns has one bit per entry, and that bit is set when the entry currently holds the key. The result appears on the match register one clock after the request.

Updating an entry takes two clocks. A shadow table remembers the key each entry holds. On the first clock of a write the block uses that old key to clear the entry's bit in the lookup table. On the second clock it sets the bit for the new key and records the new key in the shadow table. A small sequencer turns the host's write strobe into these two steps. It raises an error flag if the strobe is held longer than two clocks, and the extra clocks change nothing.

Top module: `cam_two_phase`

## Requirements
- R1: After the synchronous reset `rst`, `matchVec` is 0 and every entry holds key 0x00, so a lookup of key 0x00 returns 0xFFFF.
- R2: With `matchEn` high and `matchRst` low, `matchVec` after the next rising edge has bit e set exactly when entry e holds `key`. A lookup that shares an edge with a write sees the table contents from before that edge.
- R3: A lookup of a key that no entry holds returns 0x0000.
- R4: `matchRst` high clears `matchVec` to 0 at the next edge, even when `matchEn` is high.
- R5: With `matchEn` and `matchRst` both low, `matchVec` keeps its value.
- R6: A write holds `wrEn` high for two clocks with the same `entryIdx` (4-bit entry number, bit e of `matchVec`). The first clock removes the entry's old key. The second stores the `key` present on that clock.
- R7: Between the erase and the store edges, the entry matches no key at all. A lookup issued on the store clock does not yet report the entry.
- R8: When several entries hold the same key, a lookup of that key sets all of their bits.
- R9: When `wrEn` is held for a third and further consecutive clocks, `wrErr` is high during each of those clocks and they change no entry. `wrErr` is low whenever `wrEn` is low.
- R10: Writing an entry with the key it already holds leaves it matching that key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; loads the reset table contents |
| key | input | 8 | Lookup key; new key on the store clock of a write |
| entryIdx | input | 4 | Entry to update, held for both write clocks |
| wrEn | input | 1 | Write strobe, high for exactly two clocks per write |
| matchEn | input | 1 | Enables the lookup read into the match register |
| matchRst | input | 1 | Synchronous clear of the match register, active high |
| matchVec | output | 16 | Registered match vector, one bit per entry |
| wrErr | output | 1 | High while a write strobe is held beyond its second clock |

## Verification
The bench uses the default parameters: 8-bit keys and 16 entries. With these values the full 256-row lookup table is reachable, and so are both ends of the entry range (entries 0 and 15 through the reset contents). The bench's reference model keeps the entry keys as plain arrays with a presence flag. It is compared on every clock. This makes visible the gap between erase and store, the read-before-write ordering on a shared edge, duplicate keys in several entries, and strobes held too long. Key changes during an over-long strobe are used to show that those clocks write nothing.

// File: rtl/cam_pkg.sv
package cam_pkg;

  typedef struct packed {
    logic erase;    // clear the old key's bit for the addressed entry
    logic store;    // set the new key's bit and record the key
    logic overrun;  // strobe held past its two clocks
  } camStrobes_t;

endpackage

// File: rtl/cam_ctrl.sv
module cam_ctrl
  import cam_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  output camStrobes_t strobes
);

  logic phaseQ;  // first write clock already taken
  logic doneQ;   // second write clock already taken

  always_ff @(posedge clk) begin
    if (rst || !wrEn) begin
      phaseQ <= 1'b0;
      doneQ  <= 1'b0;
    end else if (!phaseQ) begin
      phaseQ <= 1'b1;
    end else begin
      doneQ  <= 1'b1;
    end
  end

  always_comb begin
    strobes.erase   = wrEn && !phaseQ;
    strobes.store   = wrEn && phaseQ && !doneQ;
    strobes.overrun = wrEn && doneQ;
  end

endmodule

// File: rtl/cam_datapath.sv
module cam_datapath
  import cam_pkg::*;
#(
  parameter int KEY_W   = 8,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int KEYS   = 1 << KEY_W,
  localparam int ADDR_W = KEY_W + IDX_W
) (
  input  logic               clk,
  input  logic               rst,
  input  camStrobes_t        strobes,
  input  logic [KEY_W-1:0]   key,
  input  logic [IDX_W-1:0]   entryIdx,
  input  logic               matchEn,
  input  logic               matchRst,
  output logic [ENTRIES-1:0] matchVec
);

  // lookup table: one row per key, one bit per entry
  logic [ENTRIES-1:0] lookMem [KEYS];
  // shadow table: the key each entry currently holds
  logic [KEY_W-1:0]   shadowMem [ENTRIES];
  logic [ENTRIES-1:0] matchQ;

  logic [KEY_W-1:0]   wrKey;
  logic [ADDR_W-1:0]  wrAddr;
  logic               wrBit;
  logic               wrGo;

  always_comb begin
    wrKey  = strobes.store ? key : shadowMem[entryIdx];
    wrAddr = {wrKey, entryIdx};
    wrBit  = strobes.store;
    wrGo   = strobes.erase || strobes.store;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < KEYS; k++) begin
        lookMem[k] <= (k == 0) ? {ENTRIES{1'b1}} : {ENTRIES{1'b0}};
      end
      for (int e = 0; e < ENTRIES; e++) begin
        shadowMem[e] <= '0;
      end
      matchQ <= '0;
    end else begin
      if (wrGo) begin
        lookMem[wrAddr[ADDR_W-1 -: KEY_W]][wrAddr[IDX_W-1:0]] <= wrBit;
      end
      if (strobes.store) begin
        shadowMem[entryIdx] <= key;
      end
      if (matchRst) begin
        matchQ <= '0;
      end else if (matchEn) begin
        matchQ <= lookMem[key];
      end
    end
  end

  assign matchVec = matchQ;

endmodule

// File: rtl/cam_two_phase.sv
module cam_two_phase
  import cam_pkg::*;
#(
  parameter int KEY_W   = 8,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [KEY_W-1:0]   key,
  input  logic [IDX_W-1:0]   entryIdx,
  input  logic               wrEn,
  input  logic               matchEn,
  input  logic               matchRst,
  output logic [ENTRIES-1:0] matchVec,
  output logic               wrErr
);

  camStrobes_t strobes;

  cam_ctrl i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wrEn    (wrEn),
    .strobes (strobes)
  );

  cam_datapath #(
    .KEY_W   (KEY_W),
    .ENTRIES (ENTRIES)
  ) i_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .key      (key),
    .entryIdx (entryIdx),
    .matchEn  (matchEn),
    .matchRst (matchRst),
    .matchVec (matchVec)
  );

  assign wrErr = strobes.overrun;

endmodule

// File: rtl/cam_two_phase_chk.sv
module cam_two_phase_chk #(
  parameter int ENTRIES = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               wrEn,
  input logic               matchEn,
  input logic               matchRst,
  input logic [ENTRIES-1:0] matchVec,
  input logic               wrErr
);

  assert_match_clear_R4: assert property (@(posedge clk) disable iff (rst)
    matchRst |=> (matchVec == '0));

  assert_match_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!matchEn && !matchRst) |=> $stable(matchVec));

  assert_err_needs_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    !wrEn |-> !wrErr);

  assert_err_needs_history_R9: assert property (@(posedge clk) disable iff (rst)
    wrErr |-> ($past(wrEn) && $past(wrEn, 2)));

  assert_err_persists_R9: assert property (@(posedge clk) disable iff (rst)
    (wrErr && wrEn) |=> (!wrEn || wrErr));

endmodule

bind cam_two_phase cam_two_phase_chk #(.ENTRIES(ENTRIES)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .wrEn     (wrEn),
  .matchEn  (matchEn),
  .matchRst (matchRst),
  .matchVec (matchVec),
  .wrErr    (wrErr)
);

// File: tb/test_cam_two_phase.sv
module test_cam_two_phase;

  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  key = '0;
  logic [3:0]  entryIdx = '0;
  logic        wrEn = 1'b0;
  logic        matchEn = 1'b0;
  logic        matchRst = 1'b0;
  logic [15:0] matchVec;
  logic        wrErr;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // reference model
  int  mKey [N];
  bit  mHere [N];
  int  mRun = 0;
  logic [15:0] mVec = '0;

  cam_two_phase i_cam_two_phase (
    .clk(clk), .rst(rst), .key(key), .entryIdx(entryIdx), .wrEn(wrEn),
    .matchEn(matchEn), .matchRst(matchRst), .matchVec(matchVec), .wrErr(wrErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] lookup(input int k);
    logic [15:0] v = '0;
    for (int e = 0; e < N; e++) v[e] = mHere[e] && (mKey[e] == k);
    return v;
  endfunction

  // drive at negedge, check wrErr, run one edge, update model, compare
  task automatic step(input string tag, input bit we, input int ix, input int k,
                      input bit me, input bit mr);
    wrEn = we; entryIdx = 4'(ix); key = 8'(k); matchEn = me; matchRst = mr;
    #1;
    check({tag, " wrErr"}, {15'b0, wrErr}, {15'b0, (we && mRun >= 2)});
    @(posedge clk);
    if (mr) mVec = '0;
    else if (me) mVec = lookup(k);
    if (we) begin
      if (mRun == 0) mHere[ix] = 1'b0;
      else if (mRun == 1) begin mKey[ix] = k; mHere[ix] = 1'b1; end
      mRun++;
    end else mRun = 0;
    @(negedge clk);
    check({tag, " matchVec"}, matchVec, mVec);
  endtask

  task automatic write(input string tag, input int ix, input int k);
    step(tag, 1'b1, ix, 0, 1'b0, 1'b0);
    step(tag, 1'b1, ix, k, 1'b0, 1'b0);
    step(tag, 1'b0, ix, k, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < N; e++) begin mKey[e] = 0; mHere[e] = 1'b1; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset matchVec", matchVec, 16'h0000);
    step("R1", 0, 0, 8'h00, 1, 0);
    check("R1 all entries key 00", matchVec, 16'hFFFF);

    write("R6", 3, 8'h5A);
    step("R2", 0, 0, 8'h5A, 1, 0);
    check("R2 entry 3", matchVec, 16'h0008);
    step("R2", 0, 0, 8'h00, 1, 0);
    check("R2 others at 00", matchVec, 16'hFFF7);
    step("R3", 0, 0, 8'h77, 1, 0);
    check("R3 absent key", matchVec, 16'h0000);

    step("R2", 0, 0, 8'h5A, 1, 0);
    step("R5", 0, 0, 8'h00, 0, 0);
    check("R5 hold", matchVec, 16'h0008);
    step("R4", 0, 0, 8'h00, 1, 1);
    check("R4 clear over enable", matchVec, 16'h0000);

    write("R8", 5, 8'hC3);
    write("R8", 9, 8'hC3);
    step("R8", 0, 0, 8'hC3, 1, 0);
    check("R8 duplicate keys", matchVec, 16'h0220);

    // rewrite entry 3 with a lookup on each write clock
    step("R2", 1, 3, 8'h5A, 1, 0);
    check("R2 read before erase", matchVec, 16'h0008);
    step("R7", 1, 3, 8'h11, 1, 0);
    check("R7 store clock lookup", matchVec, 16'h0000);
    step("R7", 0, 3, 8'h5A, 1, 0);
    check("R7 old key gone", matchVec, 16'h0000);
    step("R6", 0, 3, 8'h11, 1, 0);
    check("R6 new key", matchVec, 16'h0008);

    // over-long strobe with changing key
    step("R9", 1, 2, 8'h40, 0, 0);
    step("R9", 1, 2, 8'h40, 0, 0);
    step("R9", 1, 2, 8'h41, 0, 0);
    check("R9 wrErr third clock", {15'b0, wrErr}, 16'h0001);
    step("R9", 1, 2, 8'h42, 0, 0);
    step("R9", 0, 2, 8'h40, 1, 0);
    check("R9 stored key kept", matchVec, 16'h0004);
    step("R9", 0, 2, 8'h41, 1, 0);
    check("R9 extra clock ignored", matchVec, 16'h0000);
    step("R9", 0, 2, 8'h42, 1, 0);
    check("R9 extra clock ignored", matchVec, 16'h0000);

    write("R10", 5, 8'hC3);
    step("R10", 0, 0, 8'hC3, 1, 0);
    check("R10 same key rewrite", matchVec, 16'h0220);

    write("R6", 15, 8'hFF);
    step("R6", 0, 0, 8'hFF, 1, 0);
    check("R6 top entry", matchVec, 16'h8000);
    step("R2", 0, 0, 8'h00, 1, 0);
    check("R2 remaining at 00", matchVec, 16'h7DD3);

    finished = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule